// File: doc/BRIEF.md
# Signed Word Multiplier with Overflow Flag Update

This unit multiplies the low 32-bit halves of two 64-bit register operands, each taken as a two's-complement word, and returns the full 64-bit signed product. Anything in the upper halves of the operands is discarded. The multiplication is iterative. A one-cycle start pulse captures the operands, the 10-bit extended opcode and the incoming overflow and summary-overflow flags. After a fixed number of cycles, a one-cycle done pulse presents the product and the updated flag pair together.

Overflow means the 64-bit product does not equal its own low word sign-extended from bit 31. The flags change only when the overflow-enable bit of the extended opcode is set. In that form, an overflow sets both flags. A result that fits clears the overflow flag and leaves the summary flag as it was. In the plain form, both flags pass through unchanged.

A start that arrives while a multiplication is in progress is ignored. Issue logic should wait for `busy_o` to drop, or for `done_o`, before it sends the next operation.

Top module: `wmul_ovf`

## Requirements
- R1: `prod_o` equals the 64-bit product of `ra_i[31:0]` and `rb_i[31:0]`, each sign-extended from bit 31. Bits 63:32 of both operands have no effect on any output. `prod_o` changes only in the cycle in which `done_o` is high.
- R2: Overflow-enable is bit 9 of `xo_i`. The plain opcode 235 has it clear and the overflow form 747 has it set. No other bit of `xo_i` changes the result.
- R3: With overflow-enable set and product bits 63:32 all zero, `ov_o` equals product bit 31.
- R4: With overflow-enable set and product bits 63:32 all one, `ov_o` equals the inverse of product bit 31.
- R5: With overflow-enable set and any other pattern in product bits 63:32, `ov_o` is 1.
- R6: With overflow-enable set and an overflow, `ov_o` and `so_o` are both 1.
- R7: With overflow-enable set and no overflow, `ov_o` is 0 and `so_o` equals the `so_i` captured at start.
- R8: With overflow-enable clear, `ov_o` and `so_o` equal the `ov_i` and `so_i` captured at start.
- R9: `done_o` is high for exactly one cycle, ITERS+1 clock edges after the edge that accepted the start (33 with the defaults). `busy_o` is high from the accepting edge until the edge that raises `done_o`.
- R10: A start while `busy_o` is high is ignored. The running operation completes with its original operands, and no extra done pulse is produced.
- R11: After a synchronous active-low reset, `busy_o`, `done_o`, `prod_o`, `ov_o` and `so_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request, accepted only when idle |
| xo_i | input | 10 | Extended opcode; bit 9 is overflow-enable |
| ra_i | input | 64 | First operand register value |
| rb_i | input | 64 | Second operand register value |
| ov_i | input | 1 | Current overflow flag |
| so_i | input | 1 | Current summary-overflow flag |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | One-cycle pulse: product and flags valid |
| prod_o | output | 64 | Signed 64-bit product |
| ov_o | output | 1 | Updated overflow flag |
| so_o | output | 1 | Updated summary-overflow flag |

## Verification
The bound checker watches properties that must hold on every cycle:
- the single-cycle done pulse and its fixed distance from the accepted start;
- `busy_o` being low at done, and no restart of the latency count by a start during a run;
- the flag pair against the flags and opcode bit it captured at start;
- the overflow flag agreeing with the product's own upper-half shape;
- the product changing only at done.

Only the bench scenarios can show that the product value itself is right. This includes the boundary products that land exactly on or just past the signed 32-bit limits, the garbage placed in the operands' upper halves, and a rejected mid-run start leaving the original result intact.

// File: rtl/wmul_pkg.sv
// Shared definitions for the signed word multiplier.
// Assumes a 10-bit extended opcode whose top bit selects the overflow form.
package wmul_pkg;

    localparam int XO_W      = 10;
    localparam int XO_OE_BIT = 9;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } state_e;

    typedef struct packed {
        logic ov;
        logic so;
    } flags_t;

endpackage

// File: rtl/wmul_operand_prep.sv
// Splits one register operand into sign and magnitude of its low word.
// Assumes REG_W >= WORD_W; bits above the word are deliberately discarded.
// The magnitude of the most negative word fits WORD_W bits as unsigned.
module wmul_operand_prep #(
    parameter int WORD_W = 32,
    parameter int REG_W  = 64
) (
    input  logic [REG_W-1:0]  reg_i,
    output logic [WORD_W-1:0] mag_o,
    output logic              neg_o
);

    logic [WORD_W-1:0] word;
    logic              hi_unused;

    assign word      = reg_i[WORD_W-1:0];
    assign hi_unused = ^reg_i[REG_W-1:WORD_W];

    // Sign of the word, then its absolute value.
    always_comb begin
        neg_o = word[WORD_W-1];
        mag_o = neg_o ? (~word + WORD_W'(1)) : word;
    end

endmodule

// File: rtl/wmul_shift_add_core.sv
// Unsigned iterative multiplier that retires STEP_BITS multiplier bits per step.
// Assumes WORD_W is a multiple of STEP_BITS.
// The accumulator holds the full 2*WORD_W product after WORD_W/STEP_BITS steps.
module wmul_shift_add_core #(
    parameter int WORD_W    = 32,
    parameter int STEP_BITS = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                step_i,
    input  logic [WORD_W-1:0]   mcand_i,
    input  logic [WORD_W-1:0]   mplier_i,
    output logic [2*WORD_W-1:0] acc_o
);

    localparam int PROD_W = 2 * WORD_W;

    logic [PROD_W-1:0] acc_q;
    logic [PROD_W-1:0] mcand_q;
    logic [WORD_W-1:0] mplier_q;
    logic [PROD_W-1:0] sum;

    // Add one shifted partial product for each multiplier bit retired this step.
    always_comb begin
        sum = acc_q;
        for (int j = 0; j < STEP_BITS; j++) begin
            if (mplier_q[j]) begin
                sum = sum + (mcand_q << j);
            end
        end
    end

    // Load operands on start; advance the shift-add recurrence on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load_i) begin
            acc_q    <= '0;
            mcand_q  <= {{WORD_W{1'b0}}, mcand_i};
            mplier_q <= mplier_i;
        end else if (step_i) begin
            acc_q    <= sum;
            mcand_q  <= mcand_q << STEP_BITS;
            mplier_q <= mplier_q >> STEP_BITS;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/wmul_ovf_detect.sv
// Decides whether a signed 2*WORD_W product fits in a signed WORD_W word.
// The upper half is sorted into three cases: all zero, all one, or mixed.
module wmul_ovf_detect #(
    parameter int WORD_W = 32
) (
    input  logic [2*WORD_W-1:0] prod_i,
    output logic                ovf_o
);

    logic [WORD_W-1:0] upper;
    logic              low_sign;

    assign upper    = prod_i[2*WORD_W-1:WORD_W];
    assign low_sign = prod_i[WORD_W-1];

    // Classify the upper half against the sign of the low word.
    always_comb begin
        if (upper == '0) begin
            ovf_o = low_sign;
        end else if (upper == '1) begin
            ovf_o = ~low_sign;
        end else begin
            ovf_o = 1'b1;
        end
    end

endmodule

// File: rtl/wmul_ovf.sv
// Top level of the signed word multiplier with overflow flag update.
// A start pulse in idle captures operands, opcode and incoming flags.
// The core runs ITERS steps, one cycle applies sign and flags, then done pulses.
// Assumes synchronous active-low reset; starts seen while busy are dropped.
module wmul_ovf #(
    parameter int WORD_W    = 32,
    parameter int STEP_BITS = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [9:0]          xo_i,
    input  logic [2*WORD_W-1:0] ra_i,
    input  logic [2*WORD_W-1:0] rb_i,
    input  logic                ov_i,
    input  logic                so_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [2*WORD_W-1:0] prod_o,
    output logic                ov_o,
    output logic                so_o
);

    import wmul_pkg::*;

    localparam int REG_W = 2 * WORD_W;
    localparam int ITERS = WORD_W / STEP_BITS;
    localparam int CNT_W = $clog2(ITERS + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(ITERS - 1);

    state_e            state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              oe_q;
    logic              neg_q;
    flags_t            flags_in_q;
    flags_t            flags_out_q;
    flags_t            flags_nxt;
    logic [REG_W-1:0]  prod_q;
    logic              done_q;
    logic              accept;
    logic              running;
    logic              xo_unused;

    logic [1:0][REG_W-1:0]  raw_ops;
    logic [1:0][WORD_W-1:0] mags;
    logic [1:0]             negs;
    logic [REG_W-1:0]       acc;
    logic [REG_W-1:0]       prod_fix;
    logic                   ovf;

    assign accept    = start_i && (state_q == ST_IDLE);
    assign running   = (state_q == ST_RUN);
    assign xo_unused = ^(xo_i & ~(XO_W'(1) << XO_OE_BIT));
    assign raw_ops[0] = ra_i;
    assign raw_ops[1] = rb_i;

    // One sign/magnitude splitter for each operand.
    for (genvar g = 0; g < 2; g++) begin : g_prep
        wmul_operand_prep #(
            .WORD_W (WORD_W),
            .REG_W  (REG_W)
        ) u_prep (
            .reg_i (raw_ops[g]),
            .mag_o (mags[g]),
            .neg_o (negs[g])
        );
    end

    wmul_shift_add_core #(
        .WORD_W    (WORD_W),
        .STEP_BITS (STEP_BITS)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .step_i   (running),
        .mcand_i  (mags[0]),
        .mplier_i (mags[1]),
        .acc_o    (acc)
    );

    // Give the unsigned magnitude product its sign back.
    always_comb begin
        prod_fix = neg_q ? (~acc + REG_W'(1)) : acc;
    end

    wmul_ovf_detect #(
        .WORD_W (WORD_W)
    ) u_detect (
        .prod_i (prod_fix),
        .ovf_o  (ovf)
    );

    // Choose updated flags: overflow form writes OV and ORs into SO, plain form passes through.
    always_comb begin
        if (oe_q) begin
            flags_nxt.ov = ovf;
            flags_nxt.so = flags_in_q.so | ovf;
        end else begin
            flags_nxt = flags_in_q;
        end
    end

    // Sequence idle -> run (ITERS steps) -> finish -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (cnt_q == LAST_STEP) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture opcode bit, product sign and incoming flags when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q       <= 1'b0;
            neg_q      <= 1'b0;
            flags_in_q <= '0;
        end else if (accept) begin
            oe_q       <= xo_i[XO_OE_BIT];
            neg_q      <= negs[0] ^ negs[1];
            flags_in_q <= '{ov: ov_i, so: so_i};
        end
    end

    // Register the result and flags in the finish cycle and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q      <= '0;
            flags_out_q <= '0;
            done_q      <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_FIN) begin
                prod_q      <= prod_fix;
                flags_out_q <= flags_nxt;
                done_q      <= 1'b1;
            end
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = done_q;
    assign prod_o = prod_q;
    assign ov_o   = flags_out_q.ov;
    assign so_o   = flags_out_q.so;

endmodule

// File: rtl/wmul_ovf_chk.sv
// Protocol and flag checker for wmul_ovf, attached through bind.
// Keeps its own copy of the opcode bit and flags captured at an accepted start,
// plus a cycle counter used to check the fixed latency.
module wmul_ovf_chk #(
    parameter int WORD_W    = 32,
    parameter int STEP_BITS = 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic [9:0]          xo_i,
    input logic                ov_i,
    input logic                so_i,
    input logic                busy_o,
    input logic                done_o,
    input logic [2*WORD_W-1:0] prod_o,
    input logic                ov_o,
    input logic                so_o
);

    localparam int LAT  = WORD_W / STEP_BITS + 1;
    localparam int CW   = $clog2(LAT + 2);

    logic          run_q;
    logic [CW-1:0] cnt_q;
    logic          oe_q;
    logic          ov_q;
    logic          so_q;
    logic          xo_unused;

    assign xo_unused = ^xo_i[8:0];

    // Track the accepted operation: captured inputs and edges elapsed since start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            oe_q  <= 1'b0;
            ov_q  <= 1'b0;
            so_q  <= 1'b0;
        end else if (start_i && !busy_o) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            oe_q  <= xo_i[9];
            ov_q  <= ov_i;
            so_q  <= so_i;
        end else begin
            if (run_q && cnt_q != '1) begin
                cnt_q <= cnt_q + CW'(1);
            end
            if (done_o) begin
                run_q <= 1'b0;
            end
        end
    end

    p_reset_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |-> (!busy_o && !done_o && prod_o == '0 && !ov_o && !so_o));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_q && cnt_q == CW'(LAT)));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !done_o) |=> busy_o);

    p_keep_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !oe_q) |-> (ov_o == ov_q && so_o == so_q));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && oe_q && !ov_o) |-> (so_o == so_q));

    p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && oe_q && ov_o) |-> so_o);

    p_ovf_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && oe_q) |-> (ov_o == (prod_o[2*WORD_W-1:WORD_W] != {WORD_W{prod_o[WORD_W-1]}})));

    p_prod_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prod_o) |-> done_o);

endmodule

bind wmul_ovf wmul_ovf_chk #(
    .WORD_W    (WORD_W),
    .STEP_BITS (STEP_BITS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .xo_i    (xo_i),
    .ov_i    (ov_i),
    .so_i    (so_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .prod_o  (prod_o),
    .ov_o    (ov_o),
    .so_o    (so_o)
);

// File: tb/wmul_ovf_tb_top.sv
// Scoreboard bench for wmul_ovf: a driver queues expected results and a
// monitor compares them against each done pulse.
module wmul_ovf_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ITERS      = 32;
    localparam longint MAXW   = 64'sd2147483647;
    localparam longint MINW   = -64'sd2147483648;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [9:0]  xo_i = '0;
    logic [63:0] ra_i = '0;
    logic [63:0] rb_i = '0;
    logic        ov_i = 1'b0;
    logic        so_i = 1'b0;
    logic        busy_o;
    logic        done_o;
    logic [63:0] prod_o;
    logic        ov_o;
    logic        so_o;

    typedef struct {
        logic [63:0] prod;
        logic        ov;
        logic        so;
        int          due;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cyc = 0;
    logic prev_done = 1'b0;

    wmul_ovf dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .xo_i    (xo_i),
        .ra_i    (ra_i),
        .rb_i    (rb_i),
        .ov_i    (ov_i),
        .so_i    (so_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .prod_o  (prod_o),
        .ov_o    (ov_o),
        .so_o    (so_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: wait for idle, issue one operation, queue the expected result.
    task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [9:0] xo,
                         input logic ovi, input logic soi, input string tag);
        exp_t e;
        longint sa, sb, p;
        logic   ovf;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        sa  = longint'($signed(a[31:0]));
        sb  = longint'($signed(b[31:0]));
        p   = sa * sb;
        ovf = (p > MAXW) || (p < MINW);
        e.prod = p;
        if (xo == 10'd747) begin
            e.ov = ovf;
            e.so = soi | ovf;
        end else begin
            e.ov = ovi;
            e.so = soi;
        end
        e.due = cyc + ITERS + 2;
        e.tag = tag;
        q.push_back(e);
        start_i = 1'b1; ra_i = a; rb_i = b; xo_i = xo; ov_i = ovi; so_i = soi;
        @(negedge clk);
        start_i = 1'b0; ra_i = '1; rb_i = '1; ov_i = ~ovi; so_i = ~soi;
    endtask

    // Monitor: compare each done pulse against the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                check(!prev_done, "R9", "done width", 64'(prev_done), 64'd0);
                if (q.size() == 0) begin
                    check(1'b0, "R10", "unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(prod_o == e.prod, e.tag, "product", prod_o, e.prod);
                    check(ov_o == e.ov, e.tag, "ov", 64'(ov_o), 64'(e.ov));
                    check(so_o == e.so, e.tag, "so", 64'(so_o), 64'(e.so));
                    check(cyc == e.due, "R9", "latency", 64'(cyc), 64'(e.due));
                end
            end
            prev_done = done_o;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check(!busy_o && !done_o && prod_o == 64'd0 && !ov_o && !so_o, "R11",
              "reset outputs", {prod_o[59:0], busy_o, done_o, ov_o, so_o}, 64'd0);
        rst_n = 1'b1;

        issue(64'd3, 64'd5, 10'd235, 1'b0, 1'b0, "R8");
        issue(64'hDEADBEEF_00000007, 64'h12345678_FFFFFFFD, 10'd747, 1'b1, 1'b1, "R7");
        issue(64'h00000000_00010000, 64'h00000000_00008000, 10'd747, 1'b0, 1'b0, "R3");
        issue(64'h00000000_7FFFFFFF, 64'hFFFFFFFF_00000001, 10'd747, 1'b1, 1'b0, "R3");
        issue(64'h00000000_FFFF0000, 64'h00000000_00008000, 10'd747, 1'b1, 1'b0, "R4");
        issue(64'h00000000_FFFF0000, 64'h00000000_00010000, 10'd747, 1'b0, 1'b0, "R4");
        issue(64'h00000000_00010000, 64'h00000000_00010000, 10'd747, 1'b0, 1'b0, "R5");
        issue(64'h00000000_80000000, 64'h00000000_80000000, 10'd747, 1'b0, 1'b1, "R6");
        issue(64'h00000000_00010000, 64'h00000000_00010000, 10'd235, 1'b0, 1'b1, "R2");
        issue(64'h00000000_80000000, 64'h00000000_FFFFFFFF, 10'd235, 1'b1, 1'b0, "R2");
        issue(64'hFFFFFFFF_FFFFFFFF, 64'h0000FFFF_FFFFFFFF, 10'd747, 1'b0, 1'b0, "R1");
        issue(64'h0, 64'h00000000_12345678, 10'd747, 1'b1, 1'b1, "R1");

        // R10: a start during a run is ignored
        issue(64'h00000000_00001234, 64'h00000000_00005678, 10'd747, 1'b0, 1'b0, "R10");
        repeat (5) @(negedge clk);
        check(busy_o, "R10", "busy mid-run", 64'(busy_o), 64'd1);
        start_i = 1'b1; ra_i = 64'd99; rb_i = 64'd77; xo_i = 10'd235; ov_i = 1'b1; so_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;

        for (int i = 0; i < 8; i++) begin
            logic [31:0] x, y;
            x = 32'h9E3779B9 * (i + 1);
            y = 32'h7F4A7C15 ^ (x << 3);
            issue({x, y}, {y, x}, (i % 2 == 0) ? 10'd747 : 10'd235, i[0], i[1], "R1");
        end

        while (q.size() != 0) @(negedge clk);
        repeat (ITERS + 4) @(negedge clk);
        check(!busy_o && !done_o, "R10", "idle after drain", 64'(busy_o), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule